// File: doc/BRIEF.md
# Inter-Core Message Queue Unit

This unit sits inside each processor core of a small symmetric multiprocessing system. It gives the core a short, direct, point-to-point message path to every core in the system, so no shared memory or bus traffic is needed. The core reaches the unit through four control/status register addresses. It needs no memory-mapped peripheral.

For every link index the unit holds one outgoing FIFO. The FIFO's head word and a data-available flag go out to the peer core. The peer sends back a one-cycle acknowledge that pops the head. On the receive side the unit looks straight into the peer's outgoing FIFO through the mirrored ready/acknowledge/data signals. A link-select field in the control register chooses which link the two data registers address. The same register reports the free-space and data-available flags for that link. The unit raises no interrupts. In a build with a single core, every register of the unit reads as zero and does nothing.

Top module: `msgq_unit`

## Requirements
- R1: After reset the control register (0xBC2) reads 0x40000000, no link reports data available (`tx_avail_o` all zero) and no acknowledge is driven.
- R2: A write to the control register loads bit 0 as the link select. Bit 1 of the select field always reads zero, and bits 29:2 read zero. Writes to bits 31:30 have no effect on what they read.
- R3: A write to 0xBC1 pushes the written word into the FIFO of the selected link. From the next cycle that link's `tx_avail_o` bit is 1, and its slice of `tx_data_o` shows the oldest word still held. Words leave in write order, and no other link is touched.
- R4: Each outgoing FIFO holds 4 words. Control bit 30 reads 1 while the selected FIFO has free space and 0 when it is full. A write to 0xBC1 while the FIFO is full is dropped and leaves the FIFO contents unchanged.
- R5: A one-cycle `tx_ack_i` pulse on a link removes that link's head word, and the next word appears in the following cycle. An acknowledge on an empty FIFO has no effect.
- R6: A read of 0xBC0 while `rx_avail_i` of the selected link is 1 returns that link's `rx_data_i` word in the same cycle. It also raises `rx_ack_o` for that link only, for exactly that cycle. Control bit 31 reads `rx_avail_i` of the selected link.
- R7: A read of 0xBC0 while the selected link has no data returns zero and drives no acknowledge.
- R8: Address 0xBC3 behaves exactly like 0xBC2 for both reads and writes.
- R9: An access to any address outside 0xBC0..0xBC3 returns zero, pushes nothing, acknowledges nothing and leaves the link select unchanged. Read data is zero whenever `csr_re` is low.
- R10: With `NUM_CORES` = 1, all four addresses read zero. Writes change nothing, `tx_avail_o` and `tx_data_o` stay zero, and `rx_ack_o` is never raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| csr_we | input | 1 | Register write strobe |
| csr_re | input | 1 | Register read strobe |
| csr_addr | input | 12 | Register address |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data, valid in the cycle of `csr_re` |
| tx_avail_o | output | NUM_CORES | Outgoing FIFO of each link holds data |
| tx_ack_i | input | NUM_CORES | Peer pops the head of its link's FIFO |
| tx_data_o | output | 32*NUM_CORES | Head word of each outgoing FIFO |
| rx_avail_i | input | NUM_CORES | Peer FIFO of each link holds data |
| rx_ack_o | output | NUM_CORES | Pop pulse to each peer FIFO |
| rx_data_i | input | 32*NUM_CORES | Head word of each peer FIFO |

## Verification
The transmit path is swept on each link with every fill count from zero to two past capacity. This tells apart correct ordering, the full flag and dropped overflow writes, and it also shows whether a write leaks onto the unselected link. The receive path is tried with all four combinations of the two `rx_avail_i` bits under each link select. This separates a correct selection from a swapped one, and a data-gated acknowledge from an ungated one. Stray addresses, the mirrored control address, status-bit writes and a single-core build are each tried on their own. These patterns expose decode and tie-off faults that the main sweeps cannot see.

// File: rtl/msgq_pkg.sv
// Shared constants and types for the inter-core message queue unit.
// Assumes a 32-bit register width and a 12-bit register address space.
package msgq_pkg;

    localparam int XLEN   = 32;
    localparam int ADDR_W = 12;

    // Register addresses
    localparam logic [ADDR_W-1:0] ADDR_RXD     = 12'hBC0;
    localparam logic [ADDR_W-1:0] ADDR_TXD     = 12'hBC1;
    localparam logic [ADDR_W-1:0] ADDR_CTL     = 12'hBC2;
    localparam logic [ADDR_W-1:0] ADDR_CTL_ALT = 12'hBC3;

    // Control register layout
    localparam int BIT_TXFREE  = 30;
    localparam int BIT_RXAVAIL = 31;
    localparam int SEL_FIELD_W = 2;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_RXD,
        ACC_TXD,
        ACC_CTL
    } acc_e;

endpackage

// File: rtl/msgq_csr_dec.sv
// Address decoder: maps a register address onto the access kind of the unit.
// Assumes the address is stable while a strobe is high; purely combinational.
module msgq_csr_dec
    import msgq_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    output acc_e              acc_o
);

    // Classify the address; both control addresses share one kind
    always_comb begin
        unique case (addr_i)
            ADDR_RXD:     acc_o = ACC_RXD;
            ADDR_TXD:     acc_o = ACC_TXD;
            ADDR_CTL:     acc_o = ACC_CTL;
            ADDR_CTL_ALT: acc_o = ACC_CTL;
            default:      acc_o = ACC_NONE;
        endcase
    end

endmodule

// File: rtl/msgq_fifo.sv
// Outgoing message FIFO of one link: synchronous, head word shown without a read delay.
// Assumes DEPTH is a power of two and at least 2. Push while full is dropped,
// pop while empty is ignored; the flags come from the fill level at the start of the cycle.
module msgq_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic [W-1:0] data_i,
    input  logic         pop_i,
    output logic [W-1:0] head_o,
    output logic         empty_o,
    output logic         full_o
);

    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0] DEPTH_C = (AW+1)'(DEPTH);
    localparam logic [AW:0] ONE_C   = (AW+1)'(1);

    logic [AW:0]  wr_q, rd_q, fill;
    logic [W-1:0] mem_q [DEPTH];
    logic         do_push, do_pop;

    // Fill level and flags from the pointer distance
    always_comb begin
        fill    = wr_q - rd_q;
        empty_o = (fill == '0);
        full_o  = (fill == DEPTH_C);
        do_push = push_i && !full_o;
        do_pop  = pop_i && !empty_o;
        head_o  = mem_q[rd_q[AW-1:0]];
    end

    // Pointer update with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q <= '0;
            rd_q <= '0;
        end else begin
            if (do_push) wr_q <= wr_q + ONE_C;
            if (do_pop)  rd_q <= rd_q + ONE_C;
        end
    end

    // Storage write; contents need no reset
    always_ff @(posedge clk) begin
        if (do_push) mem_q[wr_q[AW-1:0]] <= data_i;
    end

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && full_o && !pop_i) |=> (fill == $past(fill)));

    // R4
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= DEPTH_C);

    // R5
    pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !empty_o && !push_i) |=> (fill + ONE_C == $past(fill)));

    // R5
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && empty_o && !push_i) |=> empty_o);

endmodule

// File: rtl/msgq_unit.sv
// Inter-core message queue unit of one core. It holds one outgoing FIFO per link
// and reads the peers' FIFOs over ready/acknowledge/data links, all through four
// register addresses. Assumes NUM_CORES is 1 to 4 and the register strobes last one cycle.
// With NUM_CORES = 1 the unit is tied off to zero.
module msgq_unit
    import msgq_pkg::*;
#(
    parameter int NUM_CORES = 2,
    parameter int FIFO_DEPTH = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      csr_we,
    input  logic                      csr_re,
    input  logic [ADDR_W-1:0]         csr_addr,
    input  logic [XLEN-1:0]           csr_wdata,
    output logic [XLEN-1:0]           csr_rdata,
    output logic [NUM_CORES-1:0]      tx_avail_o,
    input  logic [NUM_CORES-1:0]      tx_ack_i,
    output logic [NUM_CORES*XLEN-1:0] tx_data_o,
    input  logic [NUM_CORES-1:0]      rx_avail_i,
    output logic [NUM_CORES-1:0]      rx_ack_o,
    input  logic [NUM_CORES*XLEN-1:0] rx_data_i
);

    localparam int SEL_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;

    generate
        if (NUM_CORES == 1) begin : g_solo
            logic unused_inputs;
            // Single-core build: everything reads zero, inputs are absorbed
            assign unused_inputs = ^{clk, rst_n, csr_we, csr_re, csr_addr, csr_wdata,
                                     tx_ack_i, rx_avail_i, rx_data_i};
            assign csr_rdata  = '0;
            assign tx_avail_o = '0;
            assign tx_data_o  = '0;
            assign rx_ack_o   = '0;
        end else begin : g_multi
            acc_e                 acc;
            logic [SEL_W-1:0]     sel_q;
            logic [NUM_CORES-1:0] q_full, q_empty, q_push;
            logic [XLEN-1:0]      rx_word [NUM_CORES];
            logic [XLEN-1:0]      status;
            logic                 rd_fire;

            msgq_csr_dec u_dec (
                .addr_i (csr_addr),
                .acc_o  (acc)
            );

            // Link select register, only the low select bits are stored
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sel_q <= '0;
                end else if (csr_we && acc == ACC_CTL) begin
                    sel_q <= csr_wdata[SEL_W-1:0];
                end
            end

            for (genvar i = 0; i < NUM_CORES; i++) begin : g_link
                // Push strobe for this link's outgoing queue
                assign q_push[i] = csr_we && (acc == ACC_TXD) && (sel_q == SEL_W'(i));
                assign rx_word[i] = rx_data_i[i*XLEN +: XLEN];

                msgq_fifo #(
                    .W     (XLEN),
                    .DEPTH (FIFO_DEPTH)
                ) u_txq (
                    .clk     (clk),
                    .rst_n   (rst_n),
                    .push_i  (q_push[i]),
                    .data_i  (csr_wdata),
                    .pop_i   (tx_ack_i[i]),
                    .head_o  (tx_data_o[i*XLEN +: XLEN]),
                    .empty_o (q_empty[i]),
                    .full_o  (q_full[i])
                );

                // Link outputs: availability and acknowledge pulse
                assign tx_avail_o[i] = !q_empty[i];
                assign rx_ack_o[i]   = rd_fire && (sel_q == SEL_W'(i));
            end

            // A receive read consumes a word only when the peer offers one
            assign rd_fire = csr_re && (acc == ACC_RXD) && rx_avail_i[sel_q];

            // Status word for the selected link
            always_comb begin
                status = '0;
                status[SEL_W-1:0]  = sel_q;
                status[BIT_TXFREE] = !q_full[sel_q];
                status[BIT_RXAVAIL] = rx_avail_i[sel_q];
            end

            // Read multiplexer, zero outside a read strobe
            always_comb begin
                csr_rdata = '0;
                if (csr_re) begin
                    unique case (acc)
                        ACC_RXD: csr_rdata = rd_fire ? rx_word[sel_q] : '0;
                        ACC_CTL: csr_rdata = status;
                        default: csr_rdata = '0;
                    endcase
                end
            end

            // R6
            ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0(rx_ack_o));

            // R6
            ack_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (|rx_ack_o) |-> csr_re);

            // R7
            ack_with_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (|rx_ack_o) |-> (|(rx_ack_o & rx_avail_i)));

            // R9
            sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !(csr_we && acc == ACC_CTL) |=> $stable(sel_q));

            // R9
            rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !csr_re |-> (csr_rdata == '0));
        end
    endgenerate

endmodule

// File: tb/msgq_unit_test.sv
// Bench: sweeps the transmit fill levels and receive patterns of a two-core unit
// and checks a single-core build; expected values come from the requirements.
module msgq_unit_test;

    localparam int N = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic          csr_we = 0, csr_re = 0;
    logic [11:0]   csr_addr = '0;
    logic [31:0]   csr_wdata = '0, csr_rdata;
    logic [N-1:0]  tx_avail_o, tx_ack_i = '0, rx_avail_i = '0, rx_ack_o;
    logic [N*32-1:0] tx_data_o, rx_data_i = '0;

    logic        s_we = 0, s_re = 0;
    logic [11:0] s_addr = '0;
    logic [31:0] s_wdata = '0, s_rdata;
    logic [0:0]  s_tx_avail, s_tx_ack = '0, s_rx_avail = '0, s_rx_ack;
    logic [31:0] s_tx_data, s_rx_data = '0;

    int checks = 0, fails = 0;
    bit done = 0;

    msgq_unit #(.NUM_CORES(N)) uut (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_re(csr_re),
        .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .tx_avail_o(tx_avail_o), .tx_ack_i(tx_ack_i), .tx_data_o(tx_data_o),
        .rx_avail_i(rx_avail_i), .rx_ack_o(rx_ack_o), .rx_data_i(rx_data_i)
    );

    msgq_unit #(.NUM_CORES(1)) uut_solo (
        .clk(clk), .rst_n(rst_n), .csr_we(s_we), .csr_re(s_re),
        .csr_addr(s_addr), .csr_wdata(s_wdata), .csr_rdata(s_rdata),
        .tx_avail_o(s_tx_avail), .tx_ack_i(s_tx_ack), .tx_data_o(s_tx_data),
        .rx_avail_i(s_rx_avail), .rx_ack_o(s_rx_ack), .rx_data_i(s_rx_data)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        csr_we = 1; csr_addr = a; csr_wdata = d;
        @(posedge clk); #1;
        csr_we = 0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d, output logic [N-1:0] ack);
        @(negedge clk);
        csr_re = 1; csr_addr = a;
        #1;
        d = csr_rdata; ack = rx_ack_o;
        @(posedge clk); #1;
        csr_re = 0;
    endtask

    task automatic pulse_ack(input int l);
        @(negedge clk);
        tx_ack_i[l] = 1'b1;
        @(posedge clk); #1;
        tx_ack_i = '0;
    endtask

    function automatic logic [31:0] stat(input logic rxa, input logic txf, input int s);
        return {rxa, txf, 28'b0, 2'(s)};
    endfunction

    initial begin
        #(4 * 100000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [N-1:0] ack;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1 reset state
        rd(12'hBC2, d, ack);
        chk("R1 status", d, 32'h4000_0000);
        chk("R1 tx_avail", tx_avail_o, 0);
        chk("R1 rx_ack", ack, 0);

        // R2 select field and read-only bits
        wr(12'hBC2, 32'hFFFF_FFFF);
        rd(12'hBC2, d, ack);
        chk("R2 all-ones write", d, stat(0, 1, 1));
        wr(12'hBC2, 32'hC000_0002);
        rd(12'hBC2, d, ack);
        chk("R2 bit1/status write", d, stat(0, 1, 0));
        // R8 mirror address
        wr(12'hBC3, 32'h1);
        rd(12'hBC2, d, ack);
        chk("R8 write via mirror", d, stat(0, 1, 1));
        rd(12'hBC3, d, ack);
        chk("R8 read via mirror", d, stat(0, 1, 1));

        // R3 R4 R5 fill sweep on each link
        for (int l = 0; l < N; l++) begin
            wr(12'hBC2, 32'(l));
            for (int n = 0; n <= 6; n++) begin
                for (int k = 0; k < n; k++) begin
                    int c;
                    wr(12'hBC1, 32'hA000_0000 + 32'(l * 256 + n * 16 + k));
                    c = (k + 1 < 4) ? k + 1 : 4;
                    rd(12'hBC2, d, ack);
                    chk("R4 free flag", d, stat(0, c < 4, l));
                    chk("R3 avail only on link", tx_avail_o, 64'(1 << l));
                    chk("R3 head oldest", tx_data_o[l*32 +: 32], 32'hA000_0000 + 32'(l * 256 + n * 16));
                end
                for (int j = 0; j < ((n < 4) ? n : 4); j++) begin
                    #1;
                    chk("R4 R5 drain order", tx_data_o[l*32 +: 32], 32'hA000_0000 + 32'(l * 256 + n * 16 + j));
                    pulse_ack(l);
                end
                chk("R4 overflow dropped", tx_avail_o, 0);
                pulse_ack(l);
                chk("R5 ack on empty", tx_avail_o, 0);
            end
        end

        // R6 R7 receive sweep
        rx_data_i = {32'hD1D1_0001, 32'hD0D0_0000};
        for (int s = 0; s < N; s++) begin
            for (int p = 0; p < 4; p++) begin
                logic a;
                wr(12'hBC2, 32'(s));
                rx_avail_i = 2'(p);
                a = rx_avail_i[s];
                rd(12'hBC2, d, ack);
                chk("R6 rx flag", d, stat(a, 1, s));
                rd(12'hBC0, d, ack);
                if (a) begin
                    chk("R6 rx data", d, rx_data_i[s*32 +: 32]);
                    chk("R6 ack one link", ack, 64'(1 << s));
                end else begin
                    chk("R7 empty read zero", d, 0);
                    chk("R7 no ack", ack, 0);
                end
                #1 chk("R6 ack single cycle", rx_ack_o, 0);
            end
        end

        // R9 stray addresses
        wr(12'hBC2, 32'h1);
        rx_avail_i = 2'b11;
        for (int t = 0; t < 3; t++) begin
            logic [11:0] a;
            a = (t == 0) ? 12'hBC4 : (t == 1) ? 12'hBBF : 12'h000;
            wr(a, 32'h0);
            rd(a, d, ack);
            chk("R9 stray read zero", d, 0);
            chk("R9 stray no ack", ack, 0);
            chk("R9 stray no push", tx_avail_o, 0);
        end
        rd(12'hBC2, d, ack);
        chk("R9 select kept", d, stat(1, 1, 1));
        @(negedge clk);
        csr_addr = 12'hBC2;
        #1 chk("R9 no strobe zero", csr_rdata, 0);
        rx_avail_i = '0;

        // R10 single-core build
        s_rx_avail = 1'b1; s_rx_data = 32'h5555_AAAA;
        for (int a = 0; a < 4; a++) begin
            @(negedge clk);
            s_we = 1; s_addr = 12'hBC0 + 12'(a); s_wdata = 32'hFFFF_FFFF;
            @(posedge clk); #1 s_we = 0;
        end
        for (int a = 0; a < 4; a++) begin
            @(negedge clk);
            s_re = 1; s_addr = 12'hBC0 + 12'(a);
            #1;
            chk("R10 read zero", s_rdata, 0);
            chk("R10 no ack", s_rx_ack, 0);
            @(posedge clk); #1 s_re = 0;
        end
        chk("R10 tx tied", {s_tx_avail, s_tx_data}, 0);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule